// File: doc/BRIEF.md
# Transceiver Recalibration Sequencer

This block is a bus master that drives one user-requested recalibration through a transceiver's reconfiguration register port. A one-cycle start pulse launches the run. A mode input chooses between two kinds of run. A PLL run sets a single enable bit. A PMA run sets receive and transmit enables, selected by two user inputs, and also updates which calibration-busy flags the engine reports.

The run follows a fixed order. The block first asks for ownership of the internal configuration bus and polls a capability register until the grant shows. It then reads the calibration-enable word and writes back an updated copy. In PMA mode it also read-modify-writes the busy-reporting mask. It then returns the bus to the calibration engine and polls the busy status until it clears. At that point it pulses done. If either polling phase runs longer than a programmable number of cycles, the block sets an error flag and goes back to idle.

The bus uses address, read, write and waitrequest signals, with read data returned a fixed `RD_LAT` cycles after the read is accepted. States: `ST_IDLE` (waiting for start), `ST_REQ` (request write), `ST_GNT_RD`/`ST_GNT_WT` (grant poll read and its data wait), `ST_CEN_RD`/`ST_CEN_WT`/`ST_CEN_WR` (enable word read-modify-write), `ST_MSK_RD`/`ST_MSK_WT`/`ST_MSK_WR` (mask read-modify-write, PMA only), `ST_REL` (release write), `ST_BSY_RD`/`ST_BSY_WT` (busy poll), `ST_DONE` (done pulse) and `ST_FAIL` (timeout). The transitions are as follows. IDLE goes to REQ on start. REQ goes to GNT_RD when the write is accepted. GNT_WT goes to CEN_RD once bit 2 reads 0, to FAIL once the timer has expired, and back to GNT_RD otherwise. CEN_WR goes to MSK_RD in PMA mode and to REL in PLL mode. MSK_WR goes to REL. REL goes to BSY_RD. BSY_WT goes to DONE when the busy bits read clear, to FAIL once the timer has expired, and back to BSY_RD otherwise. DONE and FAIL both return to IDLE.

Top module: `recal_seq`

## Requirements
- R1: The first bus access after an accepted start is a write of 0x02 to address 0x000.
- R2: After that write the block reads the capability register (0x280 in PLL mode, 0x281 in PMA mode) repeatedly until bit 2 reads 0. It writes nothing to 0x100 before that.
- R3: In PLL mode the block reads 0x100 once and writes it back once with bit 1 set. Every other bit keeps the value that was read.
- R4: In PMA mode the write to 0x100 sets bit 1 when the RX enable is high and sets bit 5 when the TX enable is high. It always forces bit 6 to 0. Every other bit keeps the value that was read.
- R5: In PMA mode the block then reads 0x281 and writes it back with bit 5 equal to the RX enable and bit 4 equal to the TX enable. Every other bit keeps the value that was read. In PLL mode no write goes to 0x281.
- R6: After the enable updates the block writes 0x01 to address 0x000, and this is its last write of the run.
- R7: The block then polls bit 1 of 0x280 (PLL mode) or bits [1:0] of 0x281 (PMA mode) until those bits read 0. It then raises done_o for exactly one cycle.
- R8: busy_o is high from the cycle after an accepted start up to and including the done cycle. A start pulse seen while busy_o is high has no effect on the run.
- R9: If a polling phase has lasted tmo_limit_i cycles when a poll still shows the bit set, the block sets err_o, gives no done pulse and returns to idle. err_o stays set until the next accepted start.
- R10: While waitrequest is high, a pending read or write keeps its strobe, address and write data unchanged. Read data is taken RD_LAT cycles after the read is accepted.
- R11: During and just after reset, busy_o, done_o, err_o and both bus strobes are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| start_i | input | 1 | One-cycle request to begin a run |
| mode_pma_i | input | 1 | 1 selects PMA recalibration, 0 selects PLL |
| rx_en_i | input | 1 | PMA receive calibration and busy-report enable |
| tx_en_i | input | 1 | PMA transmit calibration and busy-report enable |
| tmo_limit_i | input | TW | Poll phase cycle limit |
| av_addr_o | output | AW | Bus address |
| av_rd_o | output | 1 | Bus read strobe |
| av_wr_o | output | 1 | Bus write strobe |
| av_wdata_o | output | DW | Bus write data |
| av_rdata_i | input | DW | Bus read data, valid RD_LAT cycles after acceptance |
| av_waitreq_i | input | 1 | Slave stall |
| busy_o | output | 1 | Run in progress |
| done_o | output | 1 | One-cycle completion pulse |
| err_o | output | 1 | Last run timed out |

## Verification
The main sequence is run in PLL mode and in PMA mode with RX only, TX only and both enabled. Each run starts from a different initial enable word and mask word: one with bit 6 set, one all ones, one all zeros and one with scattered high bits. This shows whether unselected bits are preserved and whether bit 6 is cleared only in PMA mode. The runs also vary the number of grant polls, the number of busy polls and the waitrequest stall length. A mismatch then separates a skipped grant wait from a wrong capability address or a lost access under stall. Directed runs cover a start pulse that arrives mid-run with a different mode, and a busy flag that never clears so that the timeout path is taken.

// File: rtl/recal_pkg.sv
package recal_pkg;

    localparam int unsigned ADR_ARB     = 'h000;
    localparam int unsigned ADR_CEN     = 'h100;
    localparam int unsigned ADR_CAP_PLL = 'h280;
    localparam int unsigned ADR_CAP_PMA = 'h281;

    localparam int unsigned ARB_REQUEST = 'h02;
    localparam int unsigned ARB_RELEASE = 'h01;

    localparam int unsigned CAP_GNT_BIT  = 2;
    localparam int unsigned CAP_PLLB_BIT = 1;
    localparam int unsigned CEN_RX_BIT   = 1;
    localparam int unsigned CEN_TX_BIT   = 5;
    localparam int unsigned CEN_OFF_BIT  = 6;
    localparam int unsigned MSK_RX_BIT   = 5;
    localparam int unsigned MSK_TX_BIT   = 4;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_REQ,
        ST_GNT_RD,
        ST_GNT_WT,
        ST_CEN_RD,
        ST_CEN_WT,
        ST_CEN_WR,
        ST_MSK_RD,
        ST_MSK_WT,
        ST_MSK_WR,
        ST_REL,
        ST_BSY_RD,
        ST_BSY_WT,
        ST_DONE,
        ST_FAIL
    } recal_state_t;

endpackage

// File: rtl/recal_rdpipe.sv
module recal_rdpipe #(
    parameter int RD_LAT = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic accept_i,
    output logic valid_o
);
    logic [RD_LAT-1:0] stage_q;

    generate
        if (RD_LAT == 1) begin : g_one
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) stage_q <= '0;
                else        stage_q <= accept_i;
            end
        end else begin : g_many
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) stage_q <= '0;
                else        stage_q <= {stage_q[RD_LAT-2:0], accept_i};
            end
        end
    endgenerate

    assign valid_o = stage_q[RD_LAT-1];
endmodule

// File: rtl/recal_timer.sv
module recal_timer #(
    parameter int TW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr_i,
    input  logic          run_i,
    input  logic [TW-1:0] limit_i,
    output logic          expired_o
);
    localparam logic [TW-1:0] CNT_MAX = '1;

    logic [TW-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                         cnt_q <= '0;
        else if (clr_i)                     cnt_q <= '0;
        else if (run_i && cnt_q != CNT_MAX) cnt_q <= cnt_q + 1'b1;
    end

    assign expired_o = (cnt_q >= limit_i);
endmodule

// File: rtl/recal_rmw.sv
module recal_rmw #(
    parameter int DW = 32
) (
    input  logic          pma_i,
    input  logic          rx_i,
    input  logic          tx_i,
    input  logic [DW-1:0] word_i,
    output logic [DW-1:0] cen_o,
    output logic [DW-1:0] msk_o
);
    import recal_pkg::*;

    always_comb begin
        cen_o = word_i;
        if (pma_i) begin
            if (rx_i) cen_o[CEN_RX_BIT] = 1'b1;
            if (tx_i) cen_o[CEN_TX_BIT] = 1'b1;
            cen_o[CEN_OFF_BIT] = 1'b0;
        end else begin
            cen_o[CEN_RX_BIT] = 1'b1;
        end
    end

    always_comb begin
        msk_o             = word_i;
        msk_o[MSK_RX_BIT] = rx_i;
        msk_o[MSK_TX_BIT] = tx_i;
    end
endmodule

// File: rtl/recal_seq.sv
module recal_seq #(
    parameter int AW     = 10,
    parameter int DW     = 32,
    parameter int TW     = 16,
    parameter int RD_LAT = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start_i,
    input  logic          mode_pma_i,
    input  logic          rx_en_i,
    input  logic          tx_en_i,
    input  logic [TW-1:0] tmo_limit_i,
    output logic [AW-1:0] av_addr_o,
    output logic          av_rd_o,
    output logic          av_wr_o,
    output logic [DW-1:0] av_wdata_o,
    input  logic [DW-1:0] av_rdata_i,
    input  logic          av_waitreq_i,
    output logic          busy_o,
    output logic          done_o,
    output logic          err_o
);
    import recal_pkg::*;

    localparam logic [AW-1:0] A_ARB = AW'(ADR_ARB);
    localparam logic [AW-1:0] A_CEN = AW'(ADR_CEN);
    localparam logic [AW-1:0] A_CPL = AW'(ADR_CAP_PLL);
    localparam logic [AW-1:0] A_CPM = AW'(ADR_CAP_PMA);
    localparam logic [DW-1:0] D_REQ = DW'(ARB_REQUEST);
    localparam logic [DW-1:0] D_REL = DW'(ARB_RELEASE);

    recal_state_t state_q, state_d;
    logic          pma_q, rx_q, tx_q, err_q;
    logic [DW-1:0] word_q;
    logic          rd_ok, wr_ok, rvalid, expired;
    logic          tmr_clr, tmr_run, cal_busy;
    logic [AW-1:0] cap_addr;
    logic [DW-1:0] cen_word, msk_word;

    assign rd_ok    = av_rd_o & ~av_waitreq_i;
    assign wr_ok    = av_wr_o & ~av_waitreq_i;
    assign cap_addr = pma_q ? A_CPM : A_CPL;
    assign cal_busy = pma_q ? (|av_rdata_i[1:0]) : av_rdata_i[CAP_PLLB_BIT];
    assign tmr_clr  = (state_q == ST_REQ) || (state_q == ST_REL);
    assign tmr_run  = (state_q == ST_GNT_RD) || (state_q == ST_GNT_WT) ||
                      (state_q == ST_BSY_RD) || (state_q == ST_BSY_WT);

    recal_rdpipe #(.RD_LAT(RD_LAT)) u_rdpipe (
        .clk      (clk),
        .rst_n    (rst_n),
        .accept_i (rd_ok),
        .valid_o  (rvalid)
    );

    recal_timer #(.TW(TW)) u_timer (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr_i     (tmr_clr),
        .run_i     (tmr_run),
        .limit_i   (tmo_limit_i),
        .expired_o (expired)
    );

    recal_rmw #(.DW(DW)) u_rmw (
        .pma_i  (pma_q),
        .rx_i   (rx_q),
        .tx_i   (tx_q),
        .word_i (word_q),
        .cen_o  (cen_word),
        .msk_o  (msk_word)
    );

    // state register and run context
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            pma_q   <= 1'b0;
            rx_q    <= 1'b0;
            tx_q    <= 1'b0;
            err_q   <= 1'b0;
            word_q  <= '0;
        end else begin
            state_q <= state_d;
            if (state_q == ST_IDLE && start_i) begin
                pma_q <= mode_pma_i;
                rx_q  <= rx_en_i;
                tx_q  <= tx_en_i;
                err_q <= 1'b0;
            end else if (state_q == ST_FAIL) begin
                err_q <= 1'b1;
            end
            if (rvalid && (state_q == ST_CEN_WT || state_q == ST_MSK_WT))
                word_q <= av_rdata_i;
        end
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (start_i) state_d = ST_REQ;
            ST_REQ:    if (wr_ok)   state_d = ST_GNT_RD;
            ST_GNT_RD: if (rd_ok)   state_d = ST_GNT_WT;
            ST_GNT_WT: if (rvalid) begin
                if (!av_rdata_i[CAP_GNT_BIT]) state_d = ST_CEN_RD;
                else if (expired)             state_d = ST_FAIL;
                else                          state_d = ST_GNT_RD;
            end
            ST_CEN_RD: if (rd_ok)   state_d = ST_CEN_WT;
            ST_CEN_WT: if (rvalid)  state_d = ST_CEN_WR;
            ST_CEN_WR: if (wr_ok)   state_d = pma_q ? ST_MSK_RD : ST_REL;
            ST_MSK_RD: if (rd_ok)   state_d = ST_MSK_WT;
            ST_MSK_WT: if (rvalid)  state_d = ST_MSK_WR;
            ST_MSK_WR: if (wr_ok)   state_d = ST_REL;
            ST_REL:    if (wr_ok)   state_d = ST_BSY_RD;
            ST_BSY_RD: if (rd_ok)   state_d = ST_BSY_WT;
            ST_BSY_WT: if (rvalid) begin
                if (!cal_busy)    state_d = ST_DONE;
                else if (expired) state_d = ST_FAIL;
                else              state_d = ST_BSY_RD;
            end
            ST_DONE:   state_d = ST_IDLE;
            ST_FAIL:   state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        av_addr_o  = '0;
        av_rd_o    = 1'b0;
        av_wr_o    = 1'b0;
        av_wdata_o = '0;
        unique case (state_q)
            ST_REQ:    begin av_wr_o = 1'b1; av_addr_o = A_ARB; av_wdata_o = D_REQ; end
            ST_GNT_RD: begin av_rd_o = 1'b1; av_addr_o = cap_addr; end
            ST_CEN_RD: begin av_rd_o = 1'b1; av_addr_o = A_CEN; end
            ST_CEN_WR: begin av_wr_o = 1'b1; av_addr_o = A_CEN; av_wdata_o = cen_word; end
            ST_MSK_RD: begin av_rd_o = 1'b1; av_addr_o = A_CPM; end
            ST_MSK_WR: begin av_wr_o = 1'b1; av_addr_o = A_CPM; av_wdata_o = msk_word; end
            ST_REL:    begin av_wr_o = 1'b1; av_addr_o = A_ARB; av_wdata_o = D_REL; end
            ST_BSY_RD: begin av_rd_o = 1'b1; av_addr_o = cap_addr; end
            default:   ;
        endcase
    end

    assign busy_o = (state_q != ST_IDLE);
    assign done_o = (state_q == ST_DONE);
    assign err_o  = err_q;
endmodule

// File: rtl/recal_seq_chk.sv
module recal_seq_chk #(
    parameter int AW = 10,
    parameter int DW = 32
) (
    input logic          clk,
    input logic          rst_n,
    input logic          start_i,
    input logic [AW-1:0] av_addr_o,
    input logic          av_rd_o,
    input logic          av_wr_o,
    input logic [DW-1:0] av_wdata_o,
    input logic          av_waitreq_i,
    input logic          busy_o,
    input logic          done_o,
    input logic          err_o
);
    p_rd_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        av_rd_o && av_waitreq_i |=> av_rd_o && $stable(av_addr_o));

    p_wr_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        av_wr_o && av_waitreq_i |=> av_wr_o && $stable(av_addr_o) && $stable(av_wdata_o));

    p_rdwr_excl_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !(av_rd_o && av_wr_o));

    p_done_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    p_done_busy_r8: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> busy_o);

    p_start_busy_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_o && start_i |=> busy_o);

    p_idle_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_o |-> !av_rd_o && !av_wr_o);

    p_err_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(err_o) |-> !busy_o && !done_o);
endmodule

bind recal_seq recal_seq_chk #(.AW(AW), .DW(DW)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .start_i      (start_i),
    .av_addr_o    (av_addr_o),
    .av_rd_o      (av_rd_o),
    .av_wr_o      (av_wr_o),
    .av_wdata_o   (av_wdata_o),
    .av_waitreq_i (av_waitreq_i),
    .busy_o       (busy_o),
    .done_o       (done_o),
    .err_o        (err_o)
);

// File: tb/tb_recal_seq.sv
`timescale 1ns/1ps
module tb_recal_seq;
    localparam int AW = 10;
    localparam int DW = 32;
    localparam int TW = 16;

    typedef struct packed {
        logic        pma;
        logic        rx;
        logic        tx;
        logic [31:0] i100;
        logic [31:0] i281;
        logic [31:0] e100;
        logic [31:0] e281;
        logic [7:0]  gnt;
        logic [7:0]  bsy;
        logic [7:0]  stall;
    } vec_t;

    localparam int NV = 5;
    localparam vec_t VECS [NV] = '{
        '{1'b0, 1'b0, 1'b0, 32'h0000_0040, 32'h0000_0000, 32'h0000_0042, 32'h0, 8'd0, 8'd0, 8'd0},
        '{1'b1, 1'b1, 1'b0, 32'h0000_00C4, 32'h0000_0030, 32'h0000_0086, 32'h0000_0020, 8'd2, 8'd3, 8'd1},
        '{1'b1, 1'b0, 1'b1, 32'h0000_0000, 32'h0000_0008, 32'h0000_0020, 32'h0000_0018, 8'd1, 8'd1, 8'd2},
        '{1'b1, 1'b1, 1'b1, 32'hFFFF_FFFF, 32'h0000_0000, 32'hFFFF_FFBF, 32'h0000_0030, 8'd0, 8'd4, 8'd0},
        '{1'b0, 1'b1, 1'b1, 32'hA5A5_0000, 32'h0000_0000, 32'hA5A5_0002, 32'h0, 8'd3, 8'd2, 8'd3}
    };

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start = 1'b0;
    logic          mode_pma = 1'b0, rx_en = 1'b0, tx_en = 1'b0;
    logic [TW-1:0] tmo_limit = 16'd1000;
    logic [AW-1:0] av_addr;
    logic          av_rd, av_wr, av_wq;
    logic [DW-1:0] av_wdata, av_rdata;
    logic          busy, done, err;

    always #4 clk = ~clk;

    recal_seq #(.AW(AW), .DW(DW), .TW(TW), .RD_LAT(2)) dut (
        .clk          (clk),
        .rst_n        (rst_n),
        .start_i      (start),
        .mode_pma_i   (mode_pma),
        .rx_en_i      (rx_en),
        .tx_en_i      (tx_en),
        .tmo_limit_i  (tmo_limit),
        .av_addr_o    (av_addr),
        .av_rd_o      (av_rd),
        .av_wr_o      (av_wr),
        .av_wdata_o   (av_wdata),
        .av_rdata_i   (av_rdata),
        .av_waitreq_i (av_wq),
        .busy_o       (busy),
        .done_o       (done),
        .err_o        (err)
    );

    // slave model configuration
    logic [31:0] c_i100 = '0, c_i281 = '0;
    int          c_gnt = 0, c_bsy = 0, c_stall = 0;

    // slave model state
    logic [31:0] m100 = '0, m281 = '0, d1 = '0, d2 = '0;
    int          gnt_left = -1, bsy_left = 0, wcnt = 0, nwr = 0, dcnt = 0;
    logic        early = 1'b0;
    logic [AW-1:0] cap_seen = '0;
    logic [AW-1:0] wa [8];
    logic [31:0]   wd [8];

    assign av_wq    = (wcnt != 0);
    assign av_rdata = d2;

    always @(posedge clk) begin
        d2 <= d1;
        if (av_rd | av_wr) begin
            if (wcnt != 0) wcnt <= wcnt - 1;
            else           wcnt <= c_stall;
        end
        if (start && !busy) begin
            nwr <= 0; m100 <= c_i100; m281 <= c_i281;
            gnt_left <= -1; bsy_left <= 0; early <= 1'b0; dcnt <= 0;
        end
        if (done) dcnt <= dcnt + 1;
        if (av_rd && !av_wq) begin
            case (av_addr)
                10'h100: d1 <= m100;
                10'h280: begin
                    d1 <= {29'd0, gnt_left != 0, bsy_left != 0, 1'b0};
                    cap_seen <= av_addr;
                    if (gnt_left > 0) gnt_left <= gnt_left - 1;
                    if (gnt_left == 0 && bsy_left > 0) bsy_left <= bsy_left - 1;
                end
                10'h281: begin
                    d1 <= {m281[31:3], gnt_left != 0, bsy_left != 0, bsy_left != 0};
                    cap_seen <= av_addr;
                    if (gnt_left > 0) gnt_left <= gnt_left - 1;
                    if (gnt_left == 0 && bsy_left > 0) bsy_left <= bsy_left - 1;
                end
                default: d1 <= 32'hDEAD_BEEF;
            endcase
        end
        if (av_wr && !av_wq) begin
            if (nwr < 8) begin wa[nwr] <= av_addr; wd[nwr] <= av_wdata; end
            nwr <= nwr + 1;
            if (av_addr == 10'h100) begin
                m100 <= av_wdata;
                if (gnt_left != 0) early <= 1'b1;
            end
            if (av_addr == 10'h281) m281 <= av_wdata;
            if (av_addr == 10'h000 && av_wdata == 32'h2) gnt_left <= c_gnt;
            if (av_addr == 10'h000 && av_wdata == 32'h1) bsy_left <= c_bsy;
        end
    end

    int n_cmp = 0, n_bad = 0;
    bit finished = 1'b0;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic cfg(input vec_t v);
        c_i100 = v.i100; c_i281 = v.i281;
        c_gnt = int'(v.gnt); c_bsy = int'(v.bsy); c_stall = int'(v.stall);
        mode_pma = v.pma; rx_en = v.rx; tx_en = v.tx;
    endtask

    task automatic pulse_start();
        @(negedge clk); start = 1'b1;
        @(negedge clk); start = 1'b0;
    endtask

    task automatic wait_end();
        for (int k = 0; k < 5000; k++) begin
            if (done || err) break;
            @(negedge clk);
        end
        @(negedge clk);
    endtask

    task automatic check_run(input vec_t v, input string tag);
        int nexp;
        nexp = v.pma ? 4 : 3;
        chk({tag, " R6 write count"}, 32'(nwr), 32'(nexp));
        chk({tag, " R1 req addr"}, 32'(wa[0]), 32'h0);
        chk({tag, " R1 req data"}, wd[0], 32'h2);
        chk({tag, " R2 no early enable"}, 32'(early), 32'h0);
        chk({tag, " R2 cap addr"}, 32'(cap_seen), v.pma ? 32'h281 : 32'h280);
        chk({tag, " R3/R4 cen addr"}, 32'(wa[1]), 32'h100);
        chk({tag, v.pma ? " R4 cen data" : " R3 cen data"}, wd[1], v.e100);
        if (v.pma) begin
            chk({tag, " R5 mask addr"}, 32'(wa[2]), 32'h281);
            chk({tag, " R5 mask data"}, wd[2], v.e281);
        end
        chk({tag, " R6 rel addr"}, 32'(wa[nexp-1]), 32'h0);
        chk({tag, " R6 rel data"}, wd[nexp-1], 32'h1);
        chk({tag, " R7 one done"}, 32'(dcnt), 32'h1);
        chk({tag, " R9 no err"}, 32'(err), 32'h0);
        chk({tag, " R8 idle after"}, 32'(busy), 32'h0);
    endtask

    initial begin
        #1_000_000;
        if (!finished) begin
            n_cmp++; n_bad++;
            $display("FAIL watchdog: run did not finish");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        // R11 reset state
        repeat (3) @(negedge clk);
        chk("R11 busy in reset", 32'(busy), 32'h0);
        chk("R11 strobes in reset", {30'd0, av_rd, av_wr}, 32'h0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R11 busy after reset", 32'(busy), 32'h0);
        chk("R11 done/err after reset", {30'd0, done, err}, 32'h0);

        // vector table: R1..R7, R10 under stalls
        for (int i = 0; i < NV; i++) begin
            cfg(VECS[i]);
            pulse_start();
            chk($sformatf("v%0d R8 busy after start", i), 32'(busy), 32'h1);
            wait_end();
            check_run(VECS[i], $sformatf("v%0d", i));
        end

        // R8: start while busy is ignored
        cfg(VECS[0]);
        c_bsy = 6; c_stall = 1;
        pulse_start();
        repeat (4) @(negedge clk);
        mode_pma = 1'b1; rx_en = 1'b1; tx_en = 1'b1;
        start = 1'b1; @(negedge clk); start = 1'b0;
        repeat (10) @(negedge clk);
        start = 1'b1; @(negedge clk); start = 1'b0;
        wait_end();
        check_run(VECS[0], "mid-start R8");
        repeat (5) @(negedge clk);
        chk("R8 no restart", 32'(busy), 32'h0);

        // R9: busy never clears
        cfg(VECS[1]);
        c_bsy = 100000; tmo_limit = 16'd40;
        pulse_start();
        wait_end();
        chk("R9 err set", 32'(err), 32'h1);
        chk("R9 no done", 32'(dcnt), 32'h0);
        chk("R9 back to idle", 32'(busy), 32'h0);
        repeat (3) @(negedge clk);
        chk("R9 err held", 32'(err), 32'h1);

        // R9: err cleared by next start, normal run after
        tmo_limit = 16'd1000;
        cfg(VECS[2]);
        pulse_start();
        chk("R9 err cleared on start", 32'(err), 32'h0);
        wait_end();
        check_run(VECS[2], "after-timeout");

        finished = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule